// File: doc/BRIEF.md
# Buffered-Compare PWM Timer

This block is a 16-bit up-counting timer that produces a pulse-width-modulated output. Two compare values control the waveform. The period value sets the cycle length. The width value sets how long the output stays at its active level. Software may write either value at any time through a plain register write port. Each value passes through a shadow buffer, and the counter compares only against the buffers. A buffer takes a new value only at the period boundary, so a rewrite never tears a running cycle.

Counting advances only on clocks where the count-clock strobe `cnt_tick` is high, so the timer can run slower than the system clock. Besides the PWM pin, the block drives a second pin that toggles once per period. It also raises two single-clock interrupt pulses: one for the period match and one for the width match.

The write port is a control path and has no back-pressure. A write presented with `wr_en` high is always taken at that clock edge. The registers have no valid/ready handshake. The streaming style does not apply to this block.

Top module: `bcp_timer`

## Requirements
- R1: While `run_en` is low, the counter holds all ones, `pwm_out` is inactive, `tog_out` is 0 and neither interrupt fires. After `run_en` rises, the first count clock rolls the counter to 0 and the PWM becomes active if the width is non-zero. The first period-match pulse follows period+2 count clocks after enable.
- R2: While running, consecutive period-match pulses are exactly period+1 count clocks apart.
- R3: In each cycle the output is active for the first `width` count clocks, counted from counter value 0. It is inactive for the remaining period−width+1 count clocks.
- R4: `wr_en` with `wr_sel`=0 writes the period register and `wr_sel`=1 writes the width register, on any clock. A value written while running first takes effect in the cycle that begins after the next period-match clear.
- R5: `per_irq` is a one-clock pulse. It appears in the clock after the count clock in which the counter held the period buffer value, and it repeats every cycle.
- R6: `wid_irq` is a one-clock pulse. It appears in the clock after the count clock in which the counter held the width buffer value. It fires once per cycle when width ≤ period and never when width > period.
- R7: A width of 0 keeps the output permanently inactive. A width greater than the period keeps the output permanently active while running.
- R8: `tog_out` inverts in the same clock as each `per_irq` pulse. It is 0 while disabled.
- R9: With `act_high`=1 the active level is 1. With `act_high`=0 the active level is 0. The inactive level is always the opposite, including while disabled.
- R10: On clocks with `cnt_tick` low, nothing advances: the counter, the outputs and the buffers are unchanged and no interrupt fires.
- R11: While disabled, both buffers follow their registers. A value written at least one clock before enable is used from the first cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cnt_tick | input | 1 | Count-clock enable strobe |
| run_en | input | 1 | Timer enable |
| act_high | input | 1 | 1: active level is high; 0: active level is low |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0 selects the period register, 1 selects the width register |
| wr_data | input | 16 | Write data |
| pwm_out | output | 1 | PWM waveform |
| tog_out | output | 1 | Toggles on each period match |
| per_irq | output | 1 | Period-match pulse |
| wid_irq | output | 1 | Width-match pulse |

## Verification
A counter that clears one value early or late changes the spacing of `per_irq` within a single period. A wrong start value shifts the first pulse after enable. A buffer that loads at the wrong moment shows up in the cycle just after a rewrite: the duty or the period changes one cycle too soon, or a cycle late. A wrong width compare shifts the active count of `pwm_out` and the count of `wid_irq` pulses in every cycle. The bench therefore measures active count clocks and pulse spacing segment by segment between period pulses.

// File: rtl/bcp_pkg.sv
package bcp_pkg;
  typedef enum logic {
    SEL_PERIOD = 1'b0,
    SEL_WIDTH  = 1'b1
  } cmp_sel_e;
  localparam int NCMP = 2;
endpackage

// File: rtl/bcp_cmp_bank.sv
module bcp_cmp_bank
  import bcp_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic         xfer,
  input  logic         wr_en,
  input  logic         wr_sel,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] per_buf,
  output logic [W-1:0] wid_buf
);
  logic [W-1:0] regs [NCMP];
  logic [W-1:0] bufs [NCMP];

  for (genvar i = 0; i < NCMP; i++) begin : g_ch
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        regs[i] <= '0;
        bufs[i] <= '0;
      end else begin
        if (wr_en && (wr_sel == 1'(i))) regs[i] <= wr_data;
        if (!run || xfer) bufs[i] <= regs[i];
      end
    end

    // R4
    buf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !xfer) |=> $stable(bufs[i]));
  end

  assign per_buf = bufs[int'(SEL_PERIOD)];
  assign wid_buf = bufs[int'(SEL_WIDTH)];
endmodule

// File: rtl/bcp_counter.sv
module bcp_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic         tick,
  input  logic [W-1:0] per_buf,
  output logic [W-1:0] cnt,
  output logic         armed,
  output logic         per_hit
);
  localparam logic [W-1:0] IDLE_VAL = '1;

  assign per_hit = run && tick && armed && (cnt == per_buf);

  always_ff @(posedge clk) begin
    if (!rst_n || !run) begin
      cnt   <= IDLE_VAL;
      armed <= 1'b0;
    end else if (tick) begin
      armed <= 1'b1;
      cnt   <= per_hit ? '0 : cnt + 1'b1;
    end
  end

  // R1
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (cnt == IDLE_VAL) && !armed);
  // R10
  tick_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !tick) |=> $stable(cnt));
  // R2
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    per_hit |=> (cnt == '0));
endmodule

// File: rtl/bcp_outgen.sv
module bcp_outgen #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic         tick,
  input  logic         armed,
  input  logic         per_hit,
  input  logic         act_high,
  input  logic [W-1:0] cnt,
  input  logic [W-1:0] wid_buf,
  output logic         pwm_out,
  output logic         tog_out,
  output logic         per_irq,
  output logic         wid_irq
);
  logic active;
  logic wid_hit;

  assign active  = armed && (cnt < wid_buf);
  assign wid_hit = run && tick && armed && (cnt == wid_buf);
  assign pwm_out = act_high ? active : !active;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      per_irq <= 1'b0;
      wid_irq <= 1'b0;
      tog_out <= 1'b0;
    end else begin
      per_irq <= per_hit;
      wid_irq <= wid_hit;
      if (!run)        tog_out <= 1'b0;
      else if (per_hit) tog_out <= !tog_out;
    end
  end

  // R5
  per_irq_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    per_irq |-> (cnt == '0));
  // R8
  tog_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run) && (tog_out != $past(tog_out))) |-> per_irq);
  // R7
  zero_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wid_buf == '0) |-> !active);
  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !per_irq && !wid_irq && !tog_out);
endmodule

// File: rtl/bcp_timer.sv
module bcp_timer
  import bcp_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cnt_tick,
  input  logic         run_en,
  input  logic         act_high,
  input  logic         wr_en,
  input  logic         wr_sel,
  input  logic [W-1:0] wr_data,
  output logic         pwm_out,
  output logic         tog_out,
  output logic         per_irq,
  output logic         wid_irq
);
  logic [W-1:0] per_buf, wid_buf, cnt;
  logic         armed, per_hit;

  bcp_cmp_bank #(.W(W)) u_bank (
    .clk(clk), .rst_n(rst_n), .run(run_en), .xfer(per_hit),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .per_buf(per_buf), .wid_buf(wid_buf)
  );

  bcp_counter #(.W(W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .run(run_en), .tick(cnt_tick),
    .per_buf(per_buf), .cnt(cnt), .armed(armed), .per_hit(per_hit)
  );

  bcp_outgen #(.W(W)) u_out (
    .clk(clk), .rst_n(rst_n), .run(run_en), .tick(cnt_tick),
    .armed(armed), .per_hit(per_hit), .act_high(act_high),
    .cnt(cnt), .wid_buf(wid_buf),
    .pwm_out(pwm_out), .tog_out(tog_out),
    .per_irq(per_irq), .wid_irq(wid_irq)
  );
endmodule

// File: tb/sim_bcp_timer.sv
`timescale 1ns/1ps
module sim_bcp_timer;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cnt_tick = 1'b0, run_en = 1'b0, act_high = 1'b1;
  logic wr_en = 1'b0, wr_sel = 1'b0;
  logic [15:0] wr_data = '0;
  logic pwm_out, tog_out, per_irq, wid_irq;
  int nchk = 0, nfail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  bcp_timer u0 (.*);

  localparam int NV = 7;
  localparam int V_PER [NV] = '{9, 9, 9, 4, 0, 2, 7};
  localparam int V_WID [NV] = '{3, 0, 12, 5, 1, 1, 7};
  localparam int V_POL [NV] = '{1, 1, 0, 1, 1, 0, 1};

  task automatic chk(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic sel, input int val);
    wr_en = 1'b1; wr_sel = sel; wr_data = 16'(val); cnt_tick = 1'b0;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // Runs until a per_irq sample; counts count clocks, active count clocks, wid_irq pulses.
  task automatic seg(input int pat, output int ticks, output int act,
                     output int wp, output int flip);
    logic t0;
    logic lvl;
    t0 = tog_out; lvl = act_high;
    ticks = 0; act = 0; wp = 0; flip = -1;
    for (int i = 0; i < 3000; i++) begin
      cnt_tick = (pat == 0) ? 1'b1 : (i % 3 != 0);
      if (cnt_tick) begin
        ticks++;
        if (pwm_out == lvl) act++;
      end
      @(negedge clk);
      if (wid_irq) wp++;
      if (per_irq) begin
        flip = (tog_out != t0) ? 1 : 0;
        break;
      end
    end
    cnt_tick = 1'b0;
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

  initial begin
    int tk, ac, wp, fl, mn, x;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 R9 reset/idle state
    chk("R1 idle pwm", pwm_out, 0);
    chk("R8 idle tog", tog_out, 0);
    chk("R5 idle per_irq", per_irq, 0);
    chk("R6 idle wid_irq", wid_irq, 0);

    // R11 R1 start-up with values written while disabled
    wr(1'b0, 5); wr(1'b1, 2);
    @(negedge clk);
    run_en = 1'b1;
    seg(0, tk, ac, wp, fl);
    chk("R1 first period ticks", tk, 7);
    chk("R11 first active", ac, 2);
    chk("R6 first wid pulses", wp, 1);
    chk("R8 toggle", fl, 1);

    // R4 buffered update: rewrite just after clear, old values hold this cycle
    wr(1'b0, 8); wr(1'b1, 4);
    seg(0, tk, ac, wp, fl);
    chk("R4 old period", tk, 6);
    chk("R4 old width", ac, 2);
    seg(0, tk, ac, wp, fl);
    chk("R4 new period", tk, 9);
    chk("R4 new width", ac, 4);

    // R10 strobe low: nothing moves
    x = pwm_out; ac = 0;
    for (int i = 0; i < 30; i++) begin
      cnt_tick = 1'b0;
      @(negedge clk);
      if (per_irq || wid_irq || (pwm_out != x)) ac++;
    end
    chk("R10 no activity without strobe", ac, 0);

    // R1 disable: idle outputs while strobe runs; R11 new values apply on enable
    run_en = 1'b0; ac = 0;
    for (int i = 0; i < 20; i++) begin
      cnt_tick = i[0];
      @(negedge clk);
      if (per_irq || wid_irq || tog_out || pwm_out) ac++;
    end
    chk("R1 disabled quiet", ac, 0);
    wr(1'b0, 3); wr(1'b1, 1);
    @(negedge clk);
    run_en = 1'b1;
    seg(1, tk, ac, wp, fl);
    chk("R11 restart period", tk, 5);
    chk("R11 restart width", ac, 1);

    // Table walk: R2 R3 R6 R7 R9
    for (int v = 0; v < NV; v++) begin
      run_en = 1'b0;
      act_high = V_POL[v][0];
      wr(1'b0, V_PER[v]); wr(1'b1, V_WID[v]);
      @(negedge clk);
      chk("R9 idle level", pwm_out, V_POL[v] ? 0 : 1);
      run_en = 1'b1;
      seg(1, tk, ac, wp, fl);
      chk("R1 table first period", tk, V_PER[v] + 2);
      mn = (V_WID[v] < V_PER[v] + 1) ? V_WID[v] : V_PER[v] + 1;
      for (int k = 0; k < 2; k++) begin
        seg(1, tk, ac, wp, fl);
        chk("R2 period", tk, V_PER[v] + 1);
        chk("R3 R7 R9 active clocks", ac, mn);
        chk("R6 wid pulses", wp, (V_WID[v] <= V_PER[v]) ? 1 : 0);
        chk("R8 toggle", fl, 1);
      end
      // R5 single-clock pulse
      cnt_tick = 1'b0;
      @(negedge clk);
      chk("R5 pulse width", per_irq, 0);
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule